// File: doc/BRIEF.md
# Self-Timed Bulk Erase Controller

This block owns the two key registers that select a bulk-erase action. A table-write path from the serial programming engine fills them one byte at a time. The byte at address 3C0005h is the upper half of a 16-bit key, and the byte at 3C0004h is the lower half. The block decodes the key into one erase region.

The serial engine reports two events to the block. One is a completed no-operation core instruction, and the other is each falling edge of the serial clock. When the fourth falling edge after a no-operation arrives and the key is valid, the block does three things in the same step:
- it emits a one-cycle strobe for the selected region;
- it clears the protection flags of that region;
- it raises `busy`, which stalls serial traffic.

`busy` stays high for a fixed, parameterised number of system clocks. The physical array erase and its analog timing are not modelled; that counter stands in for the erase time. When `busy` drops, a one-cycle `done` pulse follows and both key registers return to zero. The engine must hold the data line low while `busy` is high.

Top module: `bulk_erase_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `wipe_pulse`, `prot_flags` and `erase_key` are all zero.
- R2: A table write to 22'h3C0005 loads `erase_key[15:8]`, and a write to 22'h3C0004 loads `erase_key[7:0]`. A write to any other address leaves `erase_key` unchanged.
- R3: On a start, `wipe_pulse` is one-hot for exactly one cycle, with bits: 0 boot block, 1 to 4 code blocks 0 to 3, 5 configuration, 6 data EEPROM, 7 whole chip.
- R4: The key codes and their regions are:

  | Key | Region |
  |---|---|
  | 0F87h | whole chip |
  | 0081h | boot block |
  | 0180h | code block 0 |
  | 0280h | code block 1 |
  | 0480h | code block 2 |
  | 0880h | code block 3 |
  | 0082h | configuration |
  | 0084h | data EEPROM |

  Any other key value starts nothing: `busy` stays low and `erase_key` is unchanged.
- R5: A start happens only on the fourth `sclk_fall` strobe after a `nop_done` strobe. Fewer strobes, or strobes with no preceding `nop_done`, start nothing.
- R6: `busy` rises in the cycle that `wipe_pulse` is high and stays high for exactly ERASE_CLKS cycles.
- R7: `done` is high for exactly the one cycle after `busy` falls. In that cycle `erase_key` reads 0000h.
- R8: `prot_flags` has bits: 0 boot block, 1 to 4 code blocks 0 to 3, 5 configuration, 6 data EEPROM. A start clears the bit of the erased region, or all seven bits for a whole-chip erase, and leaves every other bit unchanged.
- R9: `prot_set` only sets `prot_flags` bits. A bit falls only at an erase start.
- R10: While `busy` is high, table writes and `nop_done` are ignored. A new erase can only follow a fresh `nop_done` after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Table-write strobe |
| tw_addr | input | 22 | Table-write address |
| tw_byte | input | 8 | Table-write data byte |
| nop_done | input | 1 | Strobe: a no-operation core instruction completed |
| sclk_fall | input | 1 | Strobe: falling edge of the serial clock |
| prot_set | input | 7 | Per-region protection set strobes |
| busy | output | 1 | Erase in progress; serial engine must stall |
| done | output | 1 | One-cycle completion pulse |
| wipe_pulse | output | 8 | One-cycle per-region erase strobe |
| prot_flags | output | 7 | Per-region code-protect flags |
| erase_key | output | 16 | Current value of the combined key registers |

## Verification
The bench targets keys that differ from a valid code by one bit. A decoder that compares only part of the key would start an erase on those keys.

It stops the trigger sequence at three falling edges, and also sends falling edges with no preceding no-operation. An off-by-one arming counter would fire in one of those cases.

It checks the length of `busy` to the exact cycle, which catches a timer that loads the wrong count. It also issues writes and no-operation strobes while `busy` is high. A design that did not gate them would show a changed key, or a second erase starting after `done`.

Protection flags are seeded at random before each erase. A design that cleared the wrong bits, or failed to clear every bit on a chip erase, shows up in `prot_flags`.

// File: rtl/erase_pkg.sv
package erase_pkg;
    localparam int ADDR_W    = 22;
    localparam int KEY_W     = 16;
    localparam int N_PROT    = 7;
    localparam int N_WIPE    = N_PROT + 1;
    localparam logic [ADDR_W-1:0] KEY_HI_ADDR = 22'h3C0005;
    localparam logic [ADDR_W-1:0] KEY_LO_ADDR = 22'h3C0004;

    // Region index order is fixed: it is the bit order on wipe_pulse / prot_flags.
    typedef enum logic [2:0] {
        RG_BOOT = 3'd0,
        RG_BLK0 = 3'd1,
        RG_BLK1 = 3'd2,
        RG_BLK2 = 3'd3,
        RG_BLK3 = 3'd4,
        RG_CFG  = 3'd5,
        RG_DATA = 3'd6,
        RG_CHIP = 3'd7
    } region_e;

    typedef struct packed {
        logic              valid;
        logic [N_WIPE-1:0] pulse;
        logic [N_PROT-1:0] clr;
    } erase_sel_t;

    function automatic erase_sel_t decode_key(input logic [KEY_W-1:0] key);
        erase_sel_t s;
        region_e    r;
        s       = '0;
        s.valid = 1'b1;
        r       = RG_CHIP;
        unique case (key)
            16'h0F87: r = RG_CHIP;
            16'h0081: r = RG_BOOT;
            16'h0082: r = RG_CFG;
            16'h0084: r = RG_DATA;
            16'h0180: r = RG_BLK0;
            16'h0280: r = RG_BLK1;
            16'h0480: r = RG_BLK2;
            16'h0880: r = RG_BLK3;
            default:  s.valid = 1'b0;
        endcase
        if (s.valid) begin
            s.pulse[r] = 1'b1;
            s.clr = (r == RG_CHIP) ? {N_PROT{1'b1}} : s.pulse[N_PROT-1:0];
        end
        return s;
    endfunction
endpackage

// File: rtl/erase_key_regs.sv
module erase_key_regs
    import erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic              clear,
    output logic [KEY_W-1:0]  key
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            key <= '0;
        end else if (wr_en) begin
            if (wr_addr == KEY_HI_ADDR) key[15:8] <= wr_byte;
            if (wr_addr == KEY_LO_ADDR) key[7:0]  <= wr_byte;
        end
    end
endmodule

// File: rtl/erase_trigger.sv
module erase_trigger #(
    parameter int EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic nop_done,
    input  logic sclk_fall,
    output logic fire
);
    localparam int CW = $clog2(EDGES);

    logic          armed;
    logic [CW-1:0] edge_cnt;

    assign fire = armed && sclk_fall && !nop_done && !hold
                  && (edge_cnt == CW'(EDGES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            edge_cnt <= '0;
        end else if (!hold) begin
            if (nop_done) begin
                armed    <= 1'b1;
                edge_cnt <= '0;
            end else if (armed && sclk_fall) begin
                if (fire) begin
                    armed    <= 1'b0;
                    edge_cnt <= '0;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
    parameter int CLKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic finish,
    output logic done
);
    localparam int CW = $clog2(CLKS + 1);

    logic [CW-1:0] remain;

    assign finish = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                busy   <= 1'b1;
                remain <= CW'(CLKS - 1);
            end else if (finish) begin
                busy <= 1'b0;
            end else if (busy) begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/bulk_erase_ctrl.sv
module bulk_erase_ctrl
    import erase_pkg::*;
#(
    parameter int ERASE_CLKS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tw_en,
    input  logic [21:0]       tw_addr,
    input  logic [7:0]        tw_byte,
    input  logic              nop_done,
    input  logic              sclk_fall,
    input  logic [6:0]        prot_set,
    output logic              busy,
    output logic              done,
    output logic [7:0]        wipe_pulse,
    output logic [6:0]        prot_flags,
    output logic [15:0]       erase_key
);
    erase_sel_t sel;
    logic       fire;
    logic       start;
    logic       finish;

    assign sel   = decode_key(erase_key);
    assign start = fire && sel.valid;

    erase_key_regs u_keys (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tw_en && !busy && !start),
        .wr_addr (tw_addr),
        .wr_byte (tw_byte),
        .clear   (finish),
        .key     (erase_key)
    );

    erase_trigger #(.EDGES(4)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .hold      (busy),
        .nop_done  (nop_done),
        .sclk_fall (sclk_fall),
        .fire      (fire)
    );

    erase_timer #(.CLKS(ERASE_CLKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .finish (finish),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wipe_pulse <= '0;
            prot_flags <= '0;
        end else begin
            wipe_pulse <= start ? sel.pulse : '0;
            prot_flags <= (prot_flags | prot_set) & ~(start ? sel.clr : '0);
        end
    end
endmodule

// File: rtl/bulk_erase_ctrl_chk.sv
module bulk_erase_ctrl_chk #(
    parameter int ERASE_CLKS = 40
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [7:0]  wipe_pulse,
    input logic [6:0]  prot_flags,
    input logic [15:0] erase_key
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= busy ? 1 : 0;
        else              run_len <= run_len + 1;
    end

    p_pulse_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wipe_pulse));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        (|wipe_pulse) |=> (wipe_pulse == '0));

    p_pulse_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (|wipe_pulse) |-> (busy && !$past(busy)));

    p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == ERASE_CLKS));

    p_done_after_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($fell(busy) && erase_key == 16'h0000));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_prot_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (|($past(prot_flags) & ~prot_flags)) |-> (|wipe_pulse));

    p_key_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(erase_key));
endmodule

bind bulk_erase_ctrl bulk_erase_ctrl_chk #(.ERASE_CLKS(ERASE_CLKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .wipe_pulse (wipe_pulse),
    .prot_flags (prot_flags),
    .erase_key  (erase_key)
);

// File: tb/bulk_erase_ctrl_bench.sv
`timescale 1ns/1ps
module bulk_erase_ctrl_bench;
    localparam int EC = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        tw_en;
    logic [21:0] tw_addr;
    logic [7:0]  tw_byte;
    logic        nop_done;
    logic        sclk_fall;
    logic [6:0]  prot_set;
    logic        busy;
    logic        done;
    logic [7:0]  wipe_pulse;
    logic [6:0]  prot_flags;
    logic [15:0] erase_key;

    int checks   = 0;
    int failures = 0;
    logic [6:0] exp_prot = '0;

    always #2.5 clk = ~clk;

    bulk_erase_ctrl #(.ERASE_CLKS(EC)) u_bulk_erase_ctrl (
        .clk(clk), .rst(rst), .tw_en(tw_en), .tw_addr(tw_addr), .tw_byte(tw_byte),
        .nop_done(nop_done), .sclk_fall(sclk_fall), .prot_set(prot_set),
        .busy(busy), .done(done), .wipe_pulse(wipe_pulse),
        .prot_flags(prot_flags), .erase_key(erase_key)
    );

    function automatic logic [7:0] exp_pulse(input logic [15:0] k);
        case (k)
            16'h0081: return 8'h01;
            16'h0180: return 8'h02;
            16'h0280: return 8'h04;
            16'h0480: return 8'h08;
            16'h0880: return 8'h10;
            16'h0082: return 8'h20;
            16'h0084: return 8'h40;
            16'h0F87: return 8'h80;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [6:0] exp_clr(input logic [7:0] p);
        return p[7] ? 7'h7F : p[6:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tw(input logic [21:0] a, input logic [7:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_addr = a; tw_byte = d;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic load_key(input logic [15:0] k);
        tw(22'h3C0005, k[15:8]);
        tw(22'h3C0004, k[7:0]);
    endtask

    task automatic set_prot(input logic [6:0] m);
        @(negedge clk);
        prot_set = m;
        @(negedge clk);
        prot_set = '0;
        exp_prot = exp_prot | m;
    endtask

    task automatic trigger(input int falls, input bit with_nop);
        if (with_nop) begin
            @(negedge clk); nop_done = 1'b1;
            @(negedge clk); nop_done = 1'b0;
        end
        for (int i = 0; i < falls; i++) begin
            @(negedge clk); sclk_fall = 1'b1;
            @(negedge clk); sclk_fall = 1'b0;
        end
    endtask

    // Called right after trigger(); samples the cycle after the 4th fall.
    task automatic expect_erase(input logic [15:0] k, input string tag);
        logic [7:0] ep;
        int n;
        ep = exp_pulse(k);
        if (ep != 0) begin
            check(busy === 1'b1, {tag, " R6 busy at start"}, busy, 1);
            check(wipe_pulse === ep, {tag, " R3 pulse"}, wipe_pulse, ep);
            exp_prot = exp_prot & ~exp_clr(ep);
            check(prot_flags === exp_prot, {tag, " R8 prot"}, prot_flags, exp_prot);
            n = 1;
            while (busy === 1'b1 && n < EC + 5) begin
                @(negedge clk);
                if (busy === 1'b1) n++;
            end
            check(n == EC, {tag, " R6 busy length"}, n, EC);
            check(done === 1'b1, {tag, " R7 done"}, done, 1);
            check(erase_key === 16'h0, {tag, " R7 key cleared"}, erase_key, 0);
            @(negedge clk);
            check(done === 1'b0, {tag, " R7 done single"}, done, 0);
        end else begin
            check(busy === 1'b0 && wipe_pulse === 8'h0, {tag, " R4 no start"},
                  {busy, wipe_pulse}, 0);
            for (int i = 0; i < EC + 2; i++) begin
                @(negedge clk);
                if (busy !== 1'b0) check(1'b0, {tag, " R4 busy rose"}, busy, 0);
            end
            check(erase_key === k, {tag, " R4 key kept"}, erase_key, k);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] keys [8];
        logic [15:0] k;
        int r;
        keys[0] = 16'h0F87; keys[1] = 16'h0081; keys[2] = 16'h0082; keys[3] = 16'h0084;
        keys[4] = 16'h0180; keys[5] = 16'h0280; keys[6] = 16'h0480; keys[7] = 16'h0880;
        void'($urandom(32'd20240611));
        rst = 1'b1; tw_en = 1'b0; tw_addr = '0; tw_byte = '0;
        nop_done = 1'b0; sclk_fall = 1'b0; prot_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, wipe_pulse, prot_flags, erase_key} === '0, "R1 reset state",
              {busy, done, wipe_pulse, prot_flags, erase_key}, 0);

        // R2: byte placement and foreign address
        tw(22'h3C0005, 8'hA5);
        check(erase_key === 16'hA500, "R2 high byte", erase_key, 16'hA500);
        tw(22'h3C0004, 8'h3C);
        check(erase_key === 16'hA53C, "R2 low byte", erase_key, 16'hA53C);
        tw(22'h3C0006, 8'hFF);
        tw(22'h1C0004, 8'hFF);
        check(erase_key === 16'hA53C, "R2 other address ignored", erase_key, 16'hA53C);

        // R5: falls without a NOP, and only three after a NOP
        load_key(16'h0081);
        trigger(4, 1'b0);
        check(busy === 1'b0, "R5 no nop no start", busy, 0);
        trigger(3, 1'b1);
        check(busy === 1'b0, "R5 three falls no start", busy, 0);
        trigger(1, 1'b0);
        expect_erase(16'h0081, "R5 fourth fall starts");

        // R3 R8: every region directed, with full protection seeded
        for (int i = 0; i < 8; i++) begin
            set_prot(7'h7F);
            load_key(keys[i]);
            trigger(4, 1'b1);
            expect_erase(keys[i], "R3 directed");
            check(prot_flags === exp_prot, "R8 others kept", prot_flags, exp_prot);
        end

        // R4: near-miss keys
        load_key(16'h0F86); trigger(4, 1'b1); expect_erase(16'h0F86, "R4 near chip");
        load_key(16'h0181); trigger(4, 1'b1); expect_erase(16'h0181, "R4 near blk0");
        load_key(16'h0080); trigger(4, 1'b1); expect_erase(16'h0080, "R4 near boot");

        // R9: protection bits only set without erase
        set_prot(7'h15);
        set_prot(7'h02);
        check(prot_flags === exp_prot, "R9 set only", prot_flags, exp_prot);

        // R10: writes and NOP during busy ignored
        load_key(16'h0084);
        trigger(4, 1'b1);
        check(busy === 1'b1, "R10 busy", busy, 1);
        @(negedge clk); tw_en = 1'b1; tw_addr = 22'h3C0004; tw_byte = 8'h81;
        @(negedge clk); tw_en = 1'b0; nop_done = 1'b1;
        @(negedge clk); nop_done = 1'b0;
        check(erase_key === 16'h0084, "R10 write ignored", erase_key, 16'h0084);
        exp_prot = exp_prot & ~7'h40;
        while (busy === 1'b1) @(negedge clk);
        load_key(16'h0081);
        trigger(4, 1'b0);
        check(busy === 1'b0, "R10 nop during busy not armed", busy, 0);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            set_prot(7'($urandom));
            r = $urandom % 10;
            k = (r < 8) ? keys[r] : 16'($urandom);
            load_key(k);
            trigger(4, 1'b1);
            expect_erase(k, "R3 random");
            check(prot_flags === exp_prot, "R8 random prot", prot_flags, exp_prot);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule